// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical address. The segment is shifted left four bits and the offset is added to it. The block keeps four segment registers: code, data, stack and extra. A write port loads them. Each cycle the caller gives an access-kind code and the current values of the candidate offset sources: the instruction pointer, the stack pointer, the base pointer, the base register, the two index registers and a displacement.

The access kind fixes both the offset source and the default segment. An optional override input can redirect the segment choice to any of the four registers. The one exception is a string destination, which always uses the extra segment. The physical address is combinational from the current segment registers and the inputs. A segment write takes effect at the next clock edge.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous) all four segment registers clear to zero. Right after reset the address therefore equals the selected offset.
- R2: When seg_wr_en is high at a rising clock edge, the segment register chosen by seg_wr_sel is loaded with seg_wr_data. The encoding is 0 = code, 1 = data, 2 = stack, 3 = extra. In the cycle the write is presented, the address still uses the old value; the new value is used from the next cycle.
- R3: phys_addr = segment × 16 + offset, taken modulo 2^20, so a carry out of bit 19 is dropped. Example: segment 34BA with offset 8AB4 gives 3D654.
- R4: acc_kind 0 (instruction fetch) uses the code segment with ip_val as the offset.
- R5: acc_kind 1 (push/pop) uses the stack segment with sp_val. acc_kind 2 (based stack access) uses the stack segment with bp_val.
- R6: The data-operand kinds use the data segment: acc_kind 3 with si_val, 4 with di_val, 5 with bx_val, and 6 with disp_val.
- R7: acc_kind 7 (string destination) uses the extra segment with di_val, whatever the override inputs hold.
- R8: When ovr_valid is high and acc_kind is not 7, the segment named by ovr_sel (same encoding as R2) replaces the default segment. The offset source is unchanged.
- R9: With seg_wr_en low, changes on seg_wr_sel and seg_wr_data leave every segment register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_sel | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | Value to write |
| acc_kind | input | 3 | Access-kind code |
| ip_val | input | 16 | Instruction pointer offset |
| sp_val | input | 16 | Stack pointer offset |
| bp_val | input | 16 | Base pointer offset |
| bx_val | input | 16 | Base register offset |
| si_val | input | 16 | Source index offset |
| di_val | input | 16 | Destination index offset |
| disp_val | input | 16 | Displacement offset |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment (0 code, 1 data, 2 stack, 3 extra) |
| phys_addr | output | 20 | Physical address |

## Verification
The address is combinational. For a change on acc_kind, the override inputs or an offset, the bench samples phys_addr a nanosecond later, in the same low clock phase and with no clock edge between. A segment write is driven at a falling edge. The bench checks the address once before the next rising edge, where it must still show the old segment, and again at the following falling edge, where it must show the new one. Writes with the enable low are held across a full rising edge before the address is compared, so any unwanted load would be visible.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int NSEG  = 4,
  parameter int KIND_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    seg_wr_en,
  input  logic [$clog2(NSEG)-1:0] seg_wr_sel,
  input  logic [SEG_W-1:0]        seg_wr_data,
  input  logic [KIND_W-1:0]       acc_kind,
  input  logic [OFF_W-1:0]        ip_val,
  input  logic [OFF_W-1:0]        sp_val,
  input  logic [OFF_W-1:0]        bp_val,
  input  logic [OFF_W-1:0]        bx_val,
  input  logic [OFF_W-1:0]        si_val,
  input  logic [OFF_W-1:0]        di_val,
  input  logic [OFF_W-1:0]        disp_val,
  input  logic                    ovr_valid,
  input  logic [$clog2(NSEG)-1:0] ovr_sel,
  output logic [SEG_W+SHIFT-1:0]  phys_addr
);
  localparam int ADDR_W = SEG_W + SHIFT;
  localparam int SEL_W  = $clog2(NSEG);

  localparam logic [SEL_W-1:0] SEG_CODE  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEG_DATA  = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEG_STACK = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEG_EXTRA = SEL_W'(3);

  localparam logic [KIND_W-1:0] K_FETCH   = KIND_W'(0);
  localparam logic [KIND_W-1:0] K_STK_SP  = KIND_W'(1);
  localparam logic [KIND_W-1:0] K_STK_BP  = KIND_W'(2);
  localparam logic [KIND_W-1:0] K_DAT_SI  = KIND_W'(3);
  localparam logic [KIND_W-1:0] K_DAT_DI  = KIND_W'(4);
  localparam logic [KIND_W-1:0] K_DAT_BX  = KIND_W'(5);
  localparam logic [KIND_W-1:0] K_DAT_DSP = KIND_W'(6);
  localparam logic [KIND_W-1:0] K_STR_DST = KIND_W'(7);

  logic [NSEG-1:0][SEG_W-1:0] seg_q;
  logic [SEL_W-1:0]           dflt_sel;
  logic [SEL_W-1:0]           eff_sel;
  logic [OFF_W-1:0]           offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seg_q <= '0;
    else if (seg_wr_en) seg_q[seg_wr_sel] <= seg_wr_data;
  end

  always_comb begin
    dflt_sel = SEG_DATA;
    offset   = disp_val;
    case (acc_kind)
      K_FETCH:   begin dflt_sel = SEG_CODE;  offset = ip_val;   end
      K_STK_SP:  begin dflt_sel = SEG_STACK; offset = sp_val;   end
      K_STK_BP:  begin dflt_sel = SEG_STACK; offset = bp_val;   end
      K_DAT_SI:  begin dflt_sel = SEG_DATA;  offset = si_val;   end
      K_DAT_DI:  begin dflt_sel = SEG_DATA;  offset = di_val;   end
      K_DAT_BX:  begin dflt_sel = SEG_DATA;  offset = bx_val;   end
      K_DAT_DSP: begin dflt_sel = SEG_DATA;  offset = disp_val; end
      K_STR_DST: begin dflt_sel = SEG_EXTRA; offset = di_val;   end
      default:   begin dflt_sel = SEG_DATA;  offset = disp_val; end
    endcase
  end

  assign eff_sel   = (ovr_valid && acc_kind != K_STR_DST) ? ovr_sel : dflt_sel;
  assign phys_addr = {seg_q[eff_sel], {SHIFT{1'b0}}} + ADDR_W'(offset);

  // Assertions
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> seg_q == '0);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_en |=> seg_q[$past(seg_wr_sel)] == $past(seg_wr_data));

  assert_no_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_wr_en |=> $stable(seg_q));

  assert_fetch_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == K_FETCH && !ovr_valid) |->
      phys_addr == ADDR_W'(seg_q[SEG_CODE]) * ADDR_W'(16) + ADDR_W'(ip_val));

  assert_string_extra_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == K_STR_DST |->
      phys_addr == ADDR_W'(seg_q[SEG_EXTRA]) * ADDR_W'(16) + ADDR_W'(di_val));

  assert_override_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && acc_kind == K_STK_SP) |->
      phys_addr == ADDR_W'(seg_q[ovr_sel]) * ADDR_W'(16) + ADDR_W'(sp_val));
endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = 2'd0;
  logic [15:0] seg_wr_data = 16'h0;
  logic [2:0]  acc_kind = 3'd0;
  logic [15:0] ip_val = 16'h0011, sp_val = 16'h0022, bp_val = 16'h0033;
  logic [15:0] bx_val = 16'h0044, si_val = 16'h0055, di_val = 16'h0066;
  logic [15:0] disp_val = 16'h0077;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_sel = 2'd0;
  logic [19:0] phys_addr;

  int checks = 0;
  int errors = 0;

  seg_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
    .seg_wr_data(seg_wr_data), .acc_kind(acc_kind), .ip_val(ip_val),
    .sp_val(sp_val), .bp_val(bp_val), .bx_val(bx_val), .si_val(si_val),
    .di_val(di_val), .disp_val(disp_val), .ovr_valid(ovr_valid),
    .ovr_sel(ovr_sel), .phys_addr(phys_addr)
  );

  always #10 clk = ~clk;

  function automatic logic [19:0] expect_addr(logic [15:0] s, logic [15:0] o);
    logic [20:0] full;
    full = {1'b0, s, 4'h0} + {5'h0, o};
    return full[19:0];
  endfunction

  task automatic check(string tag, logic [19:0] exp);
    checks++;
    if (phys_addr !== exp) begin
      errors++;
      $display("FAIL %s: phys_addr=%05h expected=%05h", tag, phys_addr, exp);
    end
  endtask

  task automatic probe(logic [2:0] k, logic ov, logic [1:0] os, string tag, logic [19:0] exp);
    acc_kind = k; ovr_valid = ov; ovr_sel = os;
    #1 check(tag, exp);
  endtask

  task automatic write_seg(logic [1:0] sel, logic [15:0] val);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
    @(negedge clk);
    seg_wr_en = 1'b0;
  endtask

  task automatic test_reset;
    probe(3'd0, 1'b0, 2'd0, "R1 code after reset", 20'h00011);
    probe(3'd7, 1'b0, 2'd0, "R1 extra after reset", 20'h00066);
  endtask

  task automatic test_load;
    write_seg(2'd0, 16'h1000);
    write_seg(2'd1, 16'h2000);
    write_seg(2'd2, 16'h3000);
    write_seg(2'd3, 16'h4000);
    #1;
    probe(3'd0, 1'b0, 2'd0, "R2 code loaded", expect_addr(16'h1000, 16'h0011));
  endtask

  task automatic test_kinds;
    probe(3'd0, 1'b0, 2'd0, "R4 fetch", expect_addr(16'h1000, ip_val));
    probe(3'd1, 1'b0, 2'd0, "R5 stack sp", expect_addr(16'h3000, sp_val));
    probe(3'd2, 1'b0, 2'd0, "R5 stack bp", expect_addr(16'h3000, bp_val));
    probe(3'd3, 1'b0, 2'd0, "R6 data si", expect_addr(16'h2000, si_val));
    probe(3'd4, 1'b0, 2'd0, "R6 data di", expect_addr(16'h2000, di_val));
    probe(3'd5, 1'b0, 2'd0, "R6 data bx", expect_addr(16'h2000, bx_val));
    probe(3'd6, 1'b0, 2'd0, "R6 data disp", expect_addr(16'h2000, disp_val));
    probe(3'd7, 1'b0, 2'd0, "R7 string dst", expect_addr(16'h4000, di_val));
  endtask

  task automatic test_override;
    probe(3'd0, 1'b1, 2'd3, "R8 fetch via extra", expect_addr(16'h4000, ip_val));
    probe(3'd1, 1'b1, 2'd1, "R8 sp via data", expect_addr(16'h2000, sp_val));
    probe(3'd6, 1'b1, 2'd2, "R8 disp via stack", expect_addr(16'h3000, disp_val));
    probe(3'd3, 1'b1, 2'd0, "R8 si via code", expect_addr(16'h1000, si_val));
    probe(3'd7, 1'b1, 2'd0, "R7 override ignored", expect_addr(16'h4000, di_val));
    probe(3'd7, 1'b1, 2'd1, "R7 override ignored data", expect_addr(16'h4000, di_val));
    ovr_valid = 1'b0;
  endtask

  task automatic test_arith;
    @(negedge clk);
    disp_val = 16'h8AB4;
    write_seg(2'd1, 16'h34BA);
    #1 probe(3'd6, 1'b0, 2'd0, "R3 worked example", 20'h3D654);
    @(negedge clk);
    disp_val = 16'hFFFF;
    write_seg(2'd1, 16'hFFFF);
    #1 probe(3'd6, 1'b0, 2'd0, "R3 wrap", 20'h0FFEF);
    @(negedge clk);
    disp_val = 16'h0077;
  endtask

  task automatic test_write_timing;
    @(negedge clk);
    acc_kind = 3'd2; ovr_valid = 1'b0;
    seg_wr_en = 1'b1; seg_wr_sel = 2'd2; seg_wr_data = 16'hABCD;
    #1 check("R2 old value in write cycle", expect_addr(16'h3000, bp_val));
    @(negedge clk);
    seg_wr_en = 1'b0;
    #1 check("R2 new value next cycle", expect_addr(16'hABCD, bp_val));
  endtask

  task automatic test_no_write;
    @(negedge clk);
    seg_wr_en = 1'b0; seg_wr_sel = 2'd0; seg_wr_data = 16'h5555;
    @(negedge clk);
    seg_wr_sel = 2'd3; seg_wr_data = 16'h6666;
    @(negedge clk);
    probe(3'd0, 1'b0, 2'd0, "R9 code unchanged", expect_addr(16'h1000, ip_val));
    probe(3'd7, 1'b0, 2'd0, "R9 extra unchanged", expect_addr(16'h4000, di_val));
  endtask

  initial begin
    #5;
    test_reset;
    #30 rst_n = 1'b1;
    #1;
    test_reset;
    test_load;
    test_kinds;
    test_override;
    test_write_timing;
    test_no_write;
    test_arith;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule